// File: doc/BRIEF.md
# Byte-Buffered APB Serial Port

This block is a serial port for an APB bus. It has one holding byte in each direction and no FIFO. Software writes a byte to the data register. The transmit serializer sends it on the TX pin as an 8N1 frame. The receive deserializer watches the RX pin and places each good frame into the receive holding byte, where software reads it back through the same data register. The bit period is a programmable number of bus clock cycles. Any divisor below sixteen keeps both serializers idle.

Status bits show that a holding byte is occupied and that a byte was lost. A byte is lost when a write overwrites a pending transmit byte, or when a new received byte overwrites one that has not been read. Those loss flags are sticky and are cleared by writing ones. The transmit and receive interrupt bits are latched events, each with its own enable. The two loss interrupt bits are not stored: they are the live product of the loss flag and its enable. Five interrupt lines leave the block: one per interrupt bit, plus their OR. A bank of read-only identification bytes sits at the top of the 4 KiB window.

Top module: `byteuart_apb`

## Requirements
- R1: After reset every register reads zero, the TX pin is high and all five interrupt outputs are low.
- R2: Word offsets 0xFD0 to 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there change nothing. Unmapped offsets (for example 0x014) read zero. PREADY is always 1 and PSLVERR always 0.
- R3: Control (offset 0x08) keeps only write bits 6:0. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the transmit interrupt, bit 3 enables the receive interrupt, bit 4 enables the transmit-loss interrupt, bit 5 enables the receive-loss interrupt, and bit 6 is stored only. The divisor register (offset 0x10) keeps write bits 19:0.
- R4: A transmitted frame is a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts the divisor value in clock cycles, and the line idles high.
- R5: Writing the data register (offset 0x00) while status bit 0 (transmit occupied) is clear sets that bit. When a frame completes, the bit clears. If control bit 2 is set, interrupt bit 0 then latches.
- R6: Writing the data register while status bit 0 is set sets status bit 2 (transmit loss). The new byte replaces the pending one, and the new byte is the one that is sent. While control bit 0 is clear, the pending byte is held and not sent.
- R7: A good frame received with control bit 1 set stores its byte and sets status bit 1 (receive occupied). If control bit 3 is set, interrupt bit 1 latches. Reading the data register returns the byte and clears status bit 1.
- R8: A good frame arriving while status bit 1 is set sets status bit 3 (receive loss), and the new byte overwrites the stored one.
- R9: Frames arriving while control bit 1 is clear are discarded, and status bit 1 stays clear.
- R10: Interrupt register (offset 0x0C) bits 2 and 3 always equal status bit 2 AND control bit 4, and status bit 3 AND control bit 5. They follow changes to the enable at once.
- R11: In the status register, bits 0 and 1 ignore writes, and writing 1 to bit 2 or 3 clears it. Writing 1 to any interrupt register bit clears that bit, and for bits 2 and 3 it also clears the matching status loss flag.
- R12: Each of the four individual interrupt outputs equals its interrupt register bit. The combined output is the OR of all four.
- R13: While the divisor is below 16, the TX pin stays high and a pending transmit byte stays pending.
- R14: A received frame whose stop bit samples low is rejected and leaves status bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and serializer clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase strobe |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, zero wait states |
| pslverr | output | 1 | Always low |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-complete interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit-loss interrupt |
| irq_rxovr | output | 1 | Receive-loss interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The properties assume the bus master follows the APB two-phase protocol: PSEL stays high through setup and access, and address and data stay stable during the access phase. They also assume that bytes on RX arrive with the same bit period as the programmed divisor. The bench drives every access through a single task that produces exactly that setup/access sequence. It generates RX traffic either by looping TX back or by driving bits held for the divisor count. It never writes the data register in the same cycle that a frame completes, so the outcome of that race stays out of the checked behaviour.

// File: rtl/byteuart_pkg.sv
// byteuart_pkg: register map, field positions and identification bytes
// shared by the serial port's register file and its checker.
package byteuart_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORD_W = ADDR_W - 2;
    localparam int CTRL_W = 7;

    typedef logic [WORD_W-1:0] word_t;

    // word indices of the mapped registers
    localparam word_t W_DATA     = word_t'(0);
    localparam word_t W_STATE    = word_t'(1);
    localparam word_t W_CTRL     = word_t'(2);
    localparam word_t W_INTR     = word_t'(3);
    localparam word_t W_BAUD     = word_t'(4);
    localparam word_t W_ID_FIRST = word_t'(12'hFD0 >> 2);

    // status bits
    localparam int S_TXFULL = 0;
    localparam int S_RXFULL = 1;
    localparam int S_TXOVR  = 2;
    localparam int S_RXOVR  = 3;

    // control bits
    localparam int C_TXEN   = 0;
    localparam int C_RXEN   = 1;
    localparam int C_TXIE   = 2;
    localparam int C_RXIE   = 3;
    localparam int C_TXOIE  = 4;
    localparam int C_RXOIE  = 5;

    // interrupt bits
    localparam int I_TX  = 0;
    localparam int I_RX  = 1;
    localparam int I_TXO = 2;
    localparam int I_RXO = 3;

    // identification byte by position counted from the first ID word
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h21;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/byteuart_tx.sv
// byteuart_tx: 8N1 serializer. Loads a byte when idle and 'go' is high and
// sends start, 8 data bits LSB first, stop; each bit lasts 'div' clocks.
// Assumes 'div' >= 1 whenever 'run' is high. 'done' is a combinational pulse
// in the last cycle of the stop bit.
module byteuart_tx #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             go,
    input  logic [7:0]       byte_in,
    input  logic [DIV_W-1:0] div,
    output logic             txd,
    output logic             done
);
    localparam int          FRAME_BITS = 10;
    localparam logic [3:0]  LAST_BIT   = 4'(FRAME_BITS - 1);

    logic                  busy;
    logic [DIV_W-1:0]      cnt;
    logic [3:0]            bitn;
    logic [FRAME_BITS-1:0] shreg;

    assign done = run && busy && (cnt == '0) && (bitn == LAST_BIT);

    // frame sequencer: bit timing, shift register and line driver
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy  <= 1'b0;
            txd   <= 1'b1;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '1;
        end else if (!busy) begin
            if (go) begin
                busy  <= 1'b1;
                shreg <= {1'b1, byte_in, 1'b0};
                txd   <= 1'b0;
                cnt   <= div - 1'b1;
                bitn  <= '0;
            end
        end else if (cnt == '0) begin
            if (bitn == LAST_BIT) begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end else begin
                bitn  <= bitn + 1'b1;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                txd   <= shreg[1];
                cnt   <= div - 1'b1;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/byteuart_rx.sv
// byteuart_rx: 8N1 deserializer. Double-synchronizes the line, starts on a
// falling edge, samples every bit mid-period and emits a one-cycle 'valid'
// only when the stop bit is high. Assumes 'div' >= 2 while 'run' is high.
module byteuart_rx #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rxd,
    input  logic [DIV_W-1:0] div,
    output logic             valid,
    output logic [7:0]       data
);
    localparam logic [3:0] STOP_BIT = 4'd9;

    logic [2:0]       sync_q;
    logic             line;
    logic             fall;
    logic             busy;
    logic [DIV_W-1:0] cnt;
    logic [3:0]       bitn;

    assign line = sync_q[1];
    assign fall = sync_q[2] && !sync_q[1];

    // synchronizer and edge history for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[1:0], rxd};
    end

    // frame sequencer: mid-bit sampling, start and stop validation
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy  <= 1'b0;
            valid <= 1'b0;
            cnt   <= '0;
            bitn  <= '0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            if (!busy) begin
                if (fall) begin
                    busy <= 1'b1;
                    cnt  <= div >> 1;
                    bitn <= '0;
                end
            end else if (cnt == '0) begin
                cnt  <= div - 1'b1;
                bitn <= bitn + 1'b1;
                if (bitn == '0) begin
                    if (line) busy <= 1'b0;
                end else if (bitn == STOP_BIT) begin
                    busy  <= 1'b0;
                    valid <= line;
                end else begin
                    data <= {line, data[7:1]};
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/byteuart_regs.sv
// byteuart_regs: APB register file, holding bytes, status flags and
// interrupt bits. Assumes single-cycle access phases (no wait states).
module byteuart_regs
    import byteuart_pkg::*;
#(
    parameter int DIV_W   = 20,
    parameter int MIN_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic              tx_go,
    output logic [DIV_W-1:0]  div,
    output logic              div_ok,
    output logic [3:0]        state_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [3:0]        intr_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  baud_q;
    logic [7:0]        txb_q, rxb_q;
    logic              tx_full_q, rx_full_q, txovr_q, rxovr_q;
    logic              int_tx_q, int_rx_q;

    word_t word, id_off;
    logic  wr, rd, wr_data, wr_state, wr_ctrl, wr_intr, wr_baud, rd_data;
    logic  rx_take, clr_txo, clr_rxo;
    logic  unused_bits;

    assign word     = paddr[ADDR_W-1:2];
    assign id_off   = word - W_ID_FIRST;
    assign wr       = psel && penable && pwrite;
    assign rd       = psel && penable && !pwrite;
    assign wr_data  = wr && (word == W_DATA);
    assign wr_state = wr && (word == W_STATE);
    assign wr_ctrl  = wr && (word == W_CTRL);
    assign wr_intr  = wr && (word == W_INTR);
    assign wr_baud  = wr && (word == W_BAUD);
    assign rd_data  = rd && (word == W_DATA);
    assign rx_take  = rx_valid && ctrl_q[C_RXEN];
    assign clr_txo  = (wr_state && pwdata[S_TXOVR]) || (wr_intr && pwdata[I_TXO]);
    assign clr_rxo  = (wr_state && pwdata[S_RXOVR]) || (wr_intr && pwdata[I_RXO]);
    assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:DIV_W], id_off[WORD_W-1:4]};

    // configuration and transmit holding byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
            txb_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= pwdata[CTRL_W-1:0];
            if (wr_baud) baud_q <= pwdata[DIV_W-1:0];
            if (wr_data) txb_q  <= pwdata[7:0];
        end
    end

    // transmit occupancy and sticky transmit-loss flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            txovr_q   <= 1'b0;
        end else begin
            if (tx_done) tx_full_q <= 1'b0;
            if (wr_data && (!tx_full_q || tx_done)) tx_full_q <= 1'b1;
            if (wr_data && tx_full_q && !tx_done) txovr_q <= 1'b1;
            else if (clr_txo)                     txovr_q <= 1'b0;
        end
    end

    // receive holding byte, occupancy and sticky receive-loss flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxb_q     <= '0;
            rx_full_q <= 1'b0;
            rxovr_q   <= 1'b0;
        end else begin
            if (rd_data) rx_full_q <= 1'b0;
            if (rx_take) begin
                rxb_q     <= rx_byte;
                rx_full_q <= 1'b1;
            end
            if (rx_take && rx_full_q && !rd_data) rxovr_q <= 1'b1;
            else if (clr_rxo)                      rxovr_q <= 1'b0;
        end
    end

    // latched transmit and receive interrupt events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_tx_q <= 1'b0;
            int_rx_q <= 1'b0;
        end else begin
            if (tx_done && ctrl_q[C_TXIE])                 int_tx_q <= 1'b1;
            else if (wr_intr && pwdata[I_TX])              int_tx_q <= 1'b0;
            if (rx_take && ctrl_q[C_RXIE])                 int_rx_q <= 1'b1;
            else if (wr_intr && pwdata[I_RX])              int_rx_q <= 1'b0;
        end
    end

    // live interrupt vector and status view
    always_comb begin
        intr_o          = '0;
        intr_o[I_TX]    = int_tx_q;
        intr_o[I_RX]    = int_rx_q;
        intr_o[I_TXO]   = txovr_q && ctrl_q[C_TXOIE];
        intr_o[I_RXO]   = rxovr_q && ctrl_q[C_RXOIE];
        state_o           = '0;
        state_o[S_TXFULL] = tx_full_q;
        state_o[S_RXFULL] = rx_full_q;
        state_o[S_TXOVR]  = txovr_q;
        state_o[S_RXOVR]  = rxovr_q;
    end

    // read data multiplexer
    always_comb begin
        prdata = '0;
        case (word)
            W_DATA:  prdata[7:0]        = rxb_q;
            W_STATE: prdata[3:0]        = state_o;
            W_CTRL:  prdata[CTRL_W-1:0] = ctrl_q;
            W_INTR:  prdata[3:0]        = intr_o;
            W_BAUD:  prdata[DIV_W-1:0]  = baud_q;
            default: if (word >= W_ID_FIRST) prdata[7:0] = id_byte(id_off[3:0]);
        endcase
    end

    assign tx_byte = txb_q;
    assign div     = baud_q;
    assign div_ok  = (baud_q >= DIV_W'(MIN_DIV));
    assign tx_go   = tx_full_q && ctrl_q[C_TXEN] && div_ok;
    assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/byteuart_apb.sv
// byteuart_apb: APB serial port with one holding byte per direction.
// Zero-wait-state slave; RX is treated as asynchronous and synchronized inside.
module byteuart_apb
    import byteuart_pkg::*;
#(
    parameter int DIV_W   = 20,
    parameter int MIN_DIV = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_txovr,
    output logic              irq_rxovr,
    output logic              irq_any
);
    logic              tx_done, tx_go, div_ok, rx_valid;
    logic [7:0]        tx_byte, rx_byte;
    logic [DIV_W-1:0]  div;
    logic [3:0]        state_w, intr_w;
    logic [CTRL_W-1:0] ctrl_w;

    byteuart_regs #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_regs (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .tx_go(tx_go), .div(div), .div_ok(div_ok),
        .state_o(state_w), .ctrl_o(ctrl_w), .intr_o(intr_w)
    );

    byteuart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(pclk), .rst_n(presetn), .run(div_ok), .go(tx_go),
        .byte_in(tx_byte), .div(div), .txd(txd), .done(tx_done)
    );

    byteuart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(pclk), .rst_n(presetn), .run(div_ok), .rxd(rxd),
        .div(div), .valid(rx_valid), .data(rx_byte)
    );

    assign pready    = 1'b1;
    assign pslverr   = 1'b0;
    assign irq_tx    = intr_w[I_TX];
    assign irq_rx    = intr_w[I_RX];
    assign irq_txovr = intr_w[I_TXO];
    assign irq_rxovr = intr_w[I_RXO];
    assign irq_any   = |intr_w;
endmodule

// File: rtl/byteuart_checker.sv
// byteuart_checker: temporal properties of the serial port, bound to the top.
// Assumes APB accesses follow the two-phase protocol.
module byteuart_checker
    import byteuart_pkg::*;
#(
    parameter int DIV_W   = 20,
    parameter int MIN_DIV = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              txd,
    input logic              irq_rxovr,
    input logic              tx_done,
    input logic              rx_valid,
    input logic [3:0]        state_w,
    input logic [CTRL_W-1:0] ctrl_w,
    input logic [DIV_W-1:0]  div
);
    logic data_write;
    assign data_write = psel && penable && pwrite && (paddr == '0);

    AST_TXFULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_w[S_TXFULL] && !tx_done |=> state_w[S_TXFULL]); // R5
    AST_TXDONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !data_write |=> !state_w[S_TXFULL]); // R5
    AST_TXLOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_w[S_TXOVR]) |-> $past(data_write)); // R6
    AST_RX_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && ctrl_w[C_RXEN] |=> state_w[S_RXFULL]); // R7
    AST_RXLOSS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxovr |-> ctrl_w[C_RXOIE] && state_w[S_RXOVR]); // R10
    AST_SLOW_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div < DIV_W'(MIN_DIV)) |=> txd); // R13
endmodule

bind byteuart_apb byteuart_checker #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_chk (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .txd(txd), .irq_rxovr(irq_rxovr),
    .tx_done(tx_done), .rx_valid(rx_valid), .state_w(state_w),
    .ctrl_w(ctrl_w), .div(div)
);

// File: tb/test_byteuart_apb.sv
`timescale 1ns/100ps
module test_byteuart_apb;
    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, txd, rxd;
    logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
    logic        loop_en = 1'b1;
    logic        drv_rx = 1'b1;
    int          n_chk = 0, n_fail = 0;
    logic        finished = 1'b0;

    assign rxd = loop_en ? txd : drv_rx;

    always #2.5 clk = ~clk;

    byteuart_apb i_byteuart_apb (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .rxd(rxd), .txd(txd),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
        .irq_rxovr(irq_rxovr), .irq_any(irq_any)
    );

    localparam logic [11:0] A_DATA = 12'h000, A_STATE = 12'h004, A_CTRL = 12'h008,
                            A_INTR = 12'h00C, A_BAUD = 12'h010, A_ID = 12'hFD0;
    localparam logic [7:0] ID_EXP [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                                           8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    // loopback vectors: {divisor, byte, interrupt enables {rx,tx}}
    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        {8'd16, 8'h00, 2'b11}, {8'd17, 8'hFF, 2'b01}, {8'd20, 8'h5A, 2'b10},
        {8'd31, 8'h81, 2'b00}, {8'd16, 8'h3C, 2'b11}, {8'd24, 8'hE7, 2'b01}};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1; #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wait_tx_empty();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            apb_rd(A_STATE, v);
            if (!v[0]) break;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic send_line(input logic [7:0] b, input logic stop, input int div);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); drv_rx = fr[i];
            repeat (div - 1) @(negedge clk);
        end
        @(negedge clk); drv_rx = 1'b1;
        repeat (2 * div) @(negedge clk);
    endtask

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [9:0]  seen;
        logic        stayed_high;
        repeat (4) @(negedge clk);
        presetn = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 irqs", {27'd0, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any}, 32'd0);
        rd_chk("R1 STATE", A_STATE, 0);
        rd_chk("R1 CTRL", A_CTRL, 0);
        rd_chk("R1 INTR", A_INTR, 0);
        rd_chk("R1 BAUD", A_BAUD, 0);
        rd_chk("R1 DATA", A_DATA, 0);

        // R2: identification bytes, read-only, unmapped reads, bus responses
        for (int i = 0; i < 12; i++) rd_chk("R2 id", A_ID + 12'(4 * i), {24'd0, ID_EXP[i]});
        apb_wr(12'hFE0, 32'hFF);
        rd_chk("R2 id write ignored", 12'hFE0, 32'h21);
        rd_chk("R2 unmapped", 12'h014, 0);
        chk("R2 pready/pslverr", {30'd0, pready, pslverr}, 32'b10);

        // R3: field widths
        apb_wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl mask", A_CTRL, 32'h7F);
        apb_wr(A_CTRL, 0);
        apb_wr(A_BAUD, 32'hFFFF_FFFF);
        rd_chk("R3 baud mask", A_BAUD, 32'hF_FFFF);

        // R13: invalid divisor keeps serializer idle; R9: receive disabled
        apb_wr(A_BAUD, 4);
        apb_wr(A_CTRL, 32'h1);
        apb_wr(A_DATA, 32'h55);
        stayed_high = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!txd) stayed_high = 1'b0;
        end
        chk("R13 txd idle", {31'd0, stayed_high}, 32'd1);
        rd_chk("R13 still pending", A_STATE, 32'h1);
        apb_wr(A_BAUD, 16);
        wait_tx_empty();
        rd_chk("R9 rx disabled discards", A_STATE, 0);

        // R4: frame shape on the line
        apb_wr(A_DATA, 32'hA6);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!txd) break;
        end
        repeat (8) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            seen[i] = txd;
            repeat (16) @(negedge clk);
        end
        chk("R4 frame bits", {22'd0, seen}, {22'd0, 1'b1, 8'hA6, 1'b0});
        wait_tx_empty();

        // loopback vector table: R5, R7, R12
        for (int k = 0; k < NVEC; k++) begin
            apb_wr(A_BAUD, {24'd0, VEC[k][17:10]});
            apb_wr(A_CTRL, {28'd0, VEC[k][1:0], 2'b11});
            apb_wr(A_INTR, 32'hF);
            apb_wr(A_DATA, {24'd0, VEC[k][9:2]});
            wait_tx_empty();
            chk("R12 irq lines", {29'd0, irq_tx, irq_rx, irq_any},
                {29'd0, VEC[k][0], VEC[k][1], |VEC[k][1:0]});
            rd_chk("R5 R7 interrupt bits", A_INTR, {30'd0, VEC[k][1:0]});
            rd_chk("R7 rx occupied", A_STATE, 32'h2);
            rd_chk("R7 byte", A_DATA, {24'd0, VEC[k][9:2]});
            rd_chk("R7 read empties", A_STATE, 0);
            apb_wr(A_INTR, 32'hF);
            chk("R11 R12 cleared", {31'd0, irq_any}, 0);
        end

        // R6 transmit loss, R10 live gating, R11 write-one-to-clear
        apb_wr(A_CTRL, 0);
        apb_wr(A_BAUD, 16);
        apb_wr(A_DATA, 32'h11);
        rd_chk("R6 held while disabled", A_STATE, 32'h1);
        apb_wr(A_DATA, 32'h22);
        rd_chk("R6 loss flagged", A_STATE, 32'h5);
        apb_wr(A_CTRL, 32'h10);
        rd_chk("R10 txo gated on", A_INTR, 32'h4);
        chk("R12 txo lines", {30'd0, irq_txovr, irq_any}, 32'b11);
        apb_wr(A_CTRL, 0);
        rd_chk("R10 txo gated off", A_INTR, 0);
        apb_wr(A_CTRL, 32'h3);
        wait_tx_empty();
        rd_chk("R6 status after send", A_STATE, 32'h6);
        rd_chk("R6 newest byte sent", A_DATA, 32'h22);
        apb_wr(A_STATE, 32'h3);
        rd_chk("R11 ro bits", A_STATE, 32'h4);
        apb_wr(A_STATE, 32'h4);
        rd_chk("R11 state w1c", A_STATE, 0);

        // R8 receive loss, R11 clear through interrupt register
        apb_wr(A_CTRL, 32'h23);
        apb_wr(A_DATA, 32'h31);
        wait_tx_empty();
        apb_wr(A_DATA, 32'h42);
        wait_tx_empty();
        rd_chk("R8 loss flagged", A_STATE, 32'hA);
        rd_chk("R10 rxo gated", A_INTR, 32'h8);
        chk("R12 rxo line", {31'd0, irq_rxovr}, 1);
        rd_chk("R8 newest kept", A_DATA, 32'h42);
        apb_wr(A_INTR, 32'h8);
        rd_chk("R11 intr clears flag", A_STATE, 0);
        chk("R11 lines low", {31'd0, irq_any}, 0);

        // R14 bad stop bit rejected, then a good driven frame accepted (R7)
        loop_en = 1'b0;
        apb_wr(A_CTRL, 32'h2);
        send_line(8'hC3, 1'b0, 16);
        rd_chk("R14 bad stop rejected", A_STATE, 0);
        send_line(8'h5A, 1'b1, 16);
        rd_chk("R7 driven frame", A_STATE, 32'h2);
        rd_chk("R7 driven byte", A_DATA, 32'h5A);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule